// File: doc/BRIEF.md
# RISC-V Debug Transport JTAG Test Access Port

This block is the serial front end of a RISC-V external debug path. It turns the three JTAG inputs (test clock, mode select and data in) into the sixteen-state test access port controller and holds a 5-bit instruction register. It places one of four data registers between data in and data out: the device identifier, a one-bit bypass stage, the transport control/status word, or the debug-module access word. On its far side it issues single read or write requests to a debug module over a valid/ready request channel and takes back a one-cycle response with data and a 2-bit status. The whole block, including the debug-module side, runs on the test clock.

The block has no dedicated reset pin. It comes up in Test-Logic-Reset through a power-up register value, and it returns there from any state after five test-clock edges with mode select held high. The reset state is decoded as its own explicit case, so its next state does not depend on a fall-through branch. A synthesis pass that re-encodes the state machine therefore cannot leave the output stuck on the bypass stage.

Top module: `dbg_jtag_tap`

## Requirements
- R1: The controller has 16 states, and every 4-bit encoding is a valid state. Sampled on the rising edge, mode select picks the next state. Capture goes to Shift on 0 and to Exit1 on 1. Shift and Pause hold on 0. Exit1 goes to Pause on 0. Exit2 goes back to Shift on 0 and to Update on 1. Update goes to Select-DR on 1 and to Run-Test/Idle on 0. Select-IR goes to Test-Logic-Reset on 1.
- R2: The controller is in Test-Logic-Reset at power-up, stays there while mode select is 1, and moves to Run-Test/Idle when it is 0. Five rising edges with mode select at 1 bring it to Test-Logic-Reset from any state.
- R3: Every rising edge in Test-Logic-Reset loads the instruction register with the identifier code 0x01.
- R4: Capture-IR loads 0b00001 into the 5-bit instruction shift stage. The stage shifts LSB first, and the new instruction takes effect at Update-IR.
- R5: The identifier register captures 0x10002FFF and shifts it out LSB first over 32 bits.
- R6: Instruction 0x10 selects the control/status word, 0x11 selects the access word, and 0x01 selects the identifier. 0x1F and every unused code select a 1-bit bypass stage that captures 0.
- R7: Data in is sampled on the rising edge. Data out and its enable change on the falling edge. The enable is 1 only in Shift-IR and Shift-DR, where data out shows bit 0 of the selected stage; elsewhere data out is 0.
- R8: The control/status word captures version 1 in bits 3:0, the address width in bits 9:4 and the sticky access status in bits 11:10, with all other bits 0. An update with bit 16 set clears the sticky status.
- R9: The access word holds op in bits 1:0, data in bits 33:2 and the address above them (op 1 = read, 2 = write). An update carrying op 1 or 2 with nothing pending raises the request valid with that address, data and op, and holds it unchanged until ready is seen.
- R10: Capturing the access word loads the last request address, the last response data, and a status field that reads 3 while a request is pending and the sticky status otherwise.
- R11: An update carrying op 1 or 2 while a request is pending issues nothing and sets the sticky status to 3 (busy).
- R12: A response with a non-zero status is recorded into the sticky status only when that status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; clocks the whole block |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| tdo | output | 1 | Serial data out, changes on the falling edge |
| tdo_oe | output | 1 | High while a shift state drives data out |
| dmi_req_valid | output | 1 | Debug-module request pending acceptance |
| dmi_req_ready | input | 1 | Debug module takes the request |
| dmi_req_addr | output | ABITS (7) | Request address |
| dmi_req_data | output | 32 | Request write data |
| dmi_req_op | output | 2 | Request op: 1 read, 2 write |
| dmi_rsp_valid | input | 1 | One-cycle response strobe |
| dmi_rsp_data | input | 32 | Response data |
| dmi_rsp_status | input | 2 | Response status, 0 meaning success |

## Verification
A controller that strays from the transition table shows up within one scan. The captured instruction bits fail to read 00001, or the data scan returns bypass zeros or a shifted identifier instead of 0x10002FFF. The data-out enable also rises one cycle early or late around pause states. A corrupted instruction or reset path can only be seen by leaving the controller in some state, giving five mode-select-high edges, and reading the identifier. A fault in the pending or sticky-status logic reaches the ports on the next access-word or control-word capture, or as a request that changes while it waits for ready.

// File: rtl/dbg_tap_pkg.sv
package dbg_tap_pkg;

   localparam int IR_W       = 5;
   localparam int DMI_DATA_W = 32;
   localparam int DMI_OP_W   = 2;
   localparam int DTMCS_W    = 32;

   localparam logic [IR_W-1:0] INS_IDCODE  = 5'h01;
   localparam logic [IR_W-1:0] INS_DTMCS   = 5'h10;
   localparam logic [IR_W-1:0] INS_DMI     = 5'h11;
   localparam logic [IR_W-1:0] INS_BYPASS  = 5'h1F;
   localparam logic [IR_W-1:0] IR_CAP_PAT  = 5'b00001;

   localparam logic [DMI_OP_W-1:0] OP_NOP    = 2'd0;
   localparam logic [DMI_OP_W-1:0] OP_READ   = 2'd1;
   localparam logic [DMI_OP_W-1:0] OP_WRITE  = 2'd2;
   localparam logic [1:0]          STAT_OK   = 2'd0;
   localparam logic [1:0]          STAT_BUSY = 2'd3;

   localparam int DTMCS_CLR_BIT = 16;

   typedef enum logic [3:0] {
      ST_EX2DR = 4'h0,
      ST_EX1DR = 4'h1,
      ST_SHDR  = 4'h2,
      ST_PDR   = 4'h3,
      ST_SELIR = 4'h4,
      ST_UPDR  = 4'h5,
      ST_CAPDR = 4'h6,
      ST_SELDR = 4'h7,
      ST_EX2IR = 4'h8,
      ST_EX1IR = 4'h9,
      ST_SHIR  = 4'hA,
      ST_PIR   = 4'hB,
      ST_IDLE  = 4'hC,
      ST_UPIR  = 4'hD,
      ST_CAPIR = 4'hE,
      ST_RESET = 4'hF
   } tap_state_e;

   typedef enum logic [1:0] {
      SEL_BYPASS,
      SEL_IDCODE,
      SEL_DTMCS,
      SEL_DMI
   } dr_sel_e;

endpackage

// File: rtl/dbg_tap_fsm.sv
module dbg_tap_fsm
   import dbg_tap_pkg::*;
(
   input  logic       tck,
   input  logic       tms,
   output tap_state_e state_o
);

   tap_state_e state_q = ST_RESET;
   tap_state_e state_d;

   always_comb begin
      state_d = ST_RESET;
      case (state_q)
         ST_RESET : state_d = tms ? ST_RESET : ST_IDLE;
         ST_IDLE  : state_d = tms ? ST_SELDR : ST_IDLE;
         ST_SELDR : state_d = tms ? ST_SELIR : ST_CAPDR;
         ST_CAPDR : state_d = tms ? ST_EX1DR : ST_SHDR;
         ST_SHDR  : state_d = tms ? ST_EX1DR : ST_SHDR;
         ST_EX1DR : state_d = tms ? ST_UPDR  : ST_PDR;
         ST_PDR   : state_d = tms ? ST_EX2DR : ST_PDR;
         ST_EX2DR : state_d = tms ? ST_UPDR  : ST_SHDR;
         ST_UPDR  : state_d = tms ? ST_SELDR : ST_IDLE;
         ST_SELIR : state_d = tms ? ST_RESET : ST_CAPIR;
         ST_CAPIR : state_d = tms ? ST_EX1IR : ST_SHIR;
         ST_SHIR  : state_d = tms ? ST_EX1IR : ST_SHIR;
         ST_EX1IR : state_d = tms ? ST_UPIR  : ST_PIR;
         ST_PIR   : state_d = tms ? ST_EX2IR : ST_PIR;
         ST_EX2IR : state_d = tms ? ST_UPIR  : ST_SHIR;
         ST_UPIR  : state_d = tms ? ST_SELDR : ST_IDLE;
         default  : state_d = ST_RESET;
      endcase
   end

   always_ff @(posedge tck) begin
      state_q <= state_d;
   end

   assign state_o = state_q;

endmodule

// File: rtl/dbg_tap_ir.sv
module dbg_tap_ir
   import dbg_tap_pkg::*;
(
   input  logic            tck,
   input  logic            tdi,
   input  tap_state_e      state,
   output logic [IR_W-1:0] ir_o,
   output logic            ir_lsb_o
);

   logic [IR_W-1:0] ir_sh = IR_CAP_PAT;
   logic [IR_W-1:0] ir_q  = INS_IDCODE;

   always_ff @(posedge tck) begin
      case (state)
         ST_CAPIR : ir_sh <= IR_CAP_PAT;
         ST_SHIR  : ir_sh <= {tdi, ir_sh[IR_W-1:1]};
         default  : ir_sh <= ir_sh;
      endcase
   end

   always_ff @(posedge tck) begin
      if (state == ST_RESET)
         ir_q <= INS_IDCODE;
      else if (state == ST_UPIR)
         ir_q <= ir_sh;
   end

   assign ir_o     = ir_q;
   assign ir_lsb_o = ir_sh[0];

endmodule

// File: rtl/dbg_tap_dr.sv
module dbg_tap_dr
   import dbg_tap_pkg::*;
#(
   parameter int          ABITS      = 7,
   parameter logic [31:0] IDCODE_VAL = 32'h1000_2FFF,
   localparam int         DR_W       = ABITS + DMI_DATA_W + DMI_OP_W
)(
   input  logic               tck,
   input  logic               tdi,
   input  tap_state_e         state,
   input  logic [IR_W-1:0]    ir,
   input  logic               ir_lsb,
   input  logic [DTMCS_W-1:0] dtmcs_cap,
   input  logic [DR_W-1:0]    dmi_cap,
   output logic [DR_W-1:0]    dr_o,
   output logic               tdo_o,
   output logic               tdo_oe_o,
   output logic               upd_dmi_o,
   output logic               upd_dtmcs_o
);

   localparam int LW = $clog2(DR_W + 1);

   dr_sel_e           sel;
   logic [LW-1:0]     dr_len;
   logic [DR_W-1:0]   cap_val;
   logic [DR_W-1:0]   sh_next;
   logic [DR_W-1:0]   dr_q  = '0;
   logic              tdo_q = 1'b0;
   logic              oe_q  = 1'b0;

   always_comb begin
      case (ir)
         INS_IDCODE : sel = SEL_IDCODE;
         INS_DTMCS  : sel = SEL_DTMCS;
         INS_DMI    : sel = SEL_DMI;
         default    : sel = SEL_BYPASS;
      endcase
   end

   always_comb begin
      case (sel)
         SEL_IDCODE : begin dr_len = LW'(32);      cap_val = DR_W'(IDCODE_VAL); end
         SEL_DTMCS  : begin dr_len = LW'(DTMCS_W); cap_val = DR_W'(dtmcs_cap);  end
         SEL_DMI    : begin dr_len = LW'(DR_W);    cap_val = dmi_cap;           end
         default    : begin dr_len = LW'(1);       cap_val = '0;                end
      endcase
   end

   // Serial input enters at bit (length-1) of the selected register.
   generate
      for (genvar i = 0; i < DR_W - 1; i++) begin : g_sh
         assign sh_next[i] = (dr_len == LW'(i + 1)) ? tdi : dr_q[i+1];
      end
   endgenerate
   assign sh_next[DR_W-1] = tdi;

   always_ff @(posedge tck) begin
      if (state == ST_CAPDR)
         dr_q <= cap_val;
      else if (state == ST_SHDR)
         dr_q <= sh_next;
   end

   always_ff @(negedge tck) begin
      if (state == ST_SHDR) begin
         tdo_q <= dr_q[0];
         oe_q  <= 1'b1;
      end else if (state == ST_SHIR) begin
         tdo_q <= ir_lsb;
         oe_q  <= 1'b1;
      end else begin
         tdo_q <= 1'b0;
         oe_q  <= 1'b0;
      end
   end

   assign dr_o        = dr_q;
   assign tdo_o       = tdo_q;
   assign tdo_oe_o    = oe_q;
   assign upd_dmi_o   = (state == ST_UPDR) && (sel == SEL_DMI);
   assign upd_dtmcs_o = (state == ST_UPDR) && (sel == SEL_DTMCS);

endmodule

// File: rtl/dbg_tap_dmi.sv
module dbg_tap_dmi
   import dbg_tap_pkg::*;
#(
   parameter int          ABITS   = 7,
   parameter logic [3:0]  VERSION = 4'd1,
   localparam int         DR_W    = ABITS + DMI_DATA_W + DMI_OP_W
)(
   input  logic                  tck,
   input  logic                  upd_dmi,
   input  logic                  upd_dtmcs,
   input  logic [DR_W-1:0]       dr,
   input  logic                  req_ready,
   input  logic                  rsp_valid,
   input  logic [DMI_DATA_W-1:0] rsp_data,
   input  logic [1:0]            rsp_status,
   output logic                  req_valid_o,
   output logic [ABITS-1:0]      req_addr_o,
   output logic [DMI_DATA_W-1:0] req_data_o,
   output logic [DMI_OP_W-1:0]   req_op_o,
   output logic [DTMCS_W-1:0]    dtmcs_cap_o,
   output logic [DR_W-1:0]       dmi_cap_o,
   output logic                  pending_o,
   output logic [1:0]            dmistat_o
);

   logic [DMI_OP_W-1:0]   in_op;
   logic [DMI_DATA_W-1:0] in_data;
   logic [ABITS-1:0]      in_addr;
   logic                  op_active, launch, collide, rsp_take;

   logic                  req_valid_q = 1'b0;
   logic [ABITS-1:0]      req_addr_q  = '0;
   logic [DMI_DATA_W-1:0] req_data_q  = '0;
   logic [DMI_OP_W-1:0]   req_op_q    = OP_NOP;
   logic                  pending_q   = 1'b0;
   logic [1:0]            stat_q      = STAT_OK;
   logic [DMI_DATA_W-1:0] rdata_q     = '0;

   assign in_op     = dr[DMI_OP_W-1:0];
   assign in_data   = dr[DMI_OP_W +: DMI_DATA_W];
   assign in_addr   = dr[DR_W-1 -: ABITS];
   assign op_active = (in_op == OP_READ) || (in_op == OP_WRITE);
   assign launch    = upd_dmi && op_active && !pending_q;
   assign collide   = upd_dmi && op_active && pending_q;
   assign rsp_take  = rsp_valid && pending_q;

   always_ff @(posedge tck) begin
      if (launch) begin
         req_valid_q <= 1'b1;
         req_addr_q  <= in_addr;
         req_data_q  <= in_data;
         req_op_q    <= in_op;
      end else if (req_valid_q && req_ready) begin
         req_valid_q <= 1'b0;
      end
   end

   always_ff @(posedge tck) begin
      if (launch)
         pending_q <= 1'b1;
      else if (rsp_take)
         pending_q <= 1'b0;
      if (rsp_take)
         rdata_q <= rsp_data;
   end

   always_ff @(posedge tck) begin
      if (upd_dtmcs && dr[DTMCS_CLR_BIT])
         stat_q <= STAT_OK;
      else if (collide)
         stat_q <= STAT_BUSY;
      else if (rsp_take && (stat_q == STAT_OK))
         stat_q <= rsp_status;
   end

   assign dtmcs_cap_o = {20'd0, stat_q, 6'(ABITS), VERSION};
   assign dmi_cap_o   = {req_addr_q, rdata_q, (pending_q ? STAT_BUSY : stat_q)};
   assign req_valid_o = req_valid_q;
   assign req_addr_o  = req_addr_q;
   assign req_data_o  = req_data_q;
   assign req_op_o    = req_op_q;
   assign pending_o   = pending_q;
   assign dmistat_o   = stat_q;

endmodule

// File: rtl/dbg_jtag_tap.sv
module dbg_jtag_tap
   import dbg_tap_pkg::*;
#(
   parameter int          ABITS       = 7,
   parameter logic [31:0] IDCODE_VAL  = 32'h1000_2FFF,
   parameter logic [3:0]  DTM_VERSION = 4'd1
)(
   input  logic             tck,
   input  logic             tms,
   input  logic             tdi,
   output logic             tdo,
   output logic             tdo_oe,
   output logic             dmi_req_valid,
   input  logic             dmi_req_ready,
   output logic [ABITS-1:0] dmi_req_addr,
   output logic [31:0]      dmi_req_data,
   output logic [1:0]       dmi_req_op,
   input  logic             dmi_rsp_valid,
   input  logic [31:0]      dmi_rsp_data,
   input  logic [1:0]       dmi_rsp_status
);

   localparam int DR_W = ABITS + DMI_DATA_W + DMI_OP_W;

   generate
      if (ABITS < 1 || ABITS > 32) begin : g_bad_abits
         $error("dbg_jtag_tap: ABITS must lie in 1..32");
      end
      if (IDCODE_VAL[0] != 1'b1) begin : g_bad_idcode
         $error("dbg_jtag_tap: identifier bit 0 must be 1");
      end
   endgenerate

   tap_state_e         state;
   logic [IR_W-1:0]    ir_q;
   logic               ir_lsb;
   logic [DR_W-1:0]    dr_q;
   logic [DTMCS_W-1:0] dtmcs_cap;
   logic [DR_W-1:0]    dmi_cap;
   logic               upd_dmi, upd_dtmcs;
   logic               pending;
   logic [1:0]         dmistat;

   dbg_tap_fsm u_fsm (
      .tck     (tck),
      .tms     (tms),
      .state_o (state)
   );

   dbg_tap_ir u_ir (
      .tck      (tck),
      .tdi      (tdi),
      .state    (state),
      .ir_o     (ir_q),
      .ir_lsb_o (ir_lsb)
   );

   dbg_tap_dr #(.ABITS(ABITS), .IDCODE_VAL(IDCODE_VAL)) u_dr (
      .tck         (tck),
      .tdi         (tdi),
      .state       (state),
      .ir          (ir_q),
      .ir_lsb      (ir_lsb),
      .dtmcs_cap   (dtmcs_cap),
      .dmi_cap     (dmi_cap),
      .dr_o        (dr_q),
      .tdo_o       (tdo),
      .tdo_oe_o    (tdo_oe),
      .upd_dmi_o   (upd_dmi),
      .upd_dtmcs_o (upd_dtmcs)
   );

   dbg_tap_dmi #(.ABITS(ABITS), .VERSION(DTM_VERSION)) u_dmi (
      .tck         (tck),
      .upd_dmi     (upd_dmi),
      .upd_dtmcs   (upd_dtmcs),
      .dr          (dr_q),
      .req_ready   (dmi_req_ready),
      .rsp_valid   (dmi_rsp_valid),
      .rsp_data    (dmi_rsp_data),
      .rsp_status  (dmi_rsp_status),
      .req_valid_o (dmi_req_valid),
      .req_addr_o  (dmi_req_addr),
      .req_data_o  (dmi_req_data),
      .req_op_o    (dmi_req_op),
      .dtmcs_cap_o (dtmcs_cap),
      .dmi_cap_o   (dmi_cap),
      .pending_o   (pending),
      .dmistat_o   (dmistat)
   );

endmodule

// File: rtl/dbg_jtag_tap_chk.sv
module dbg_jtag_tap_chk
   import dbg_tap_pkg::*;
#(
   parameter int ABITS = 7
)(
   input logic             tck,
   input logic             tms,
   input tap_state_e       state,
   input logic [IR_W-1:0]  ir_q,
   input logic             tdo_oe,
   input logic             req_valid,
   input logic             req_ready,
   input logic [ABITS-1:0] req_addr,
   input logic [31:0]      req_data,
   input logic             upd_dmi,
   input logic             pending,
   input logic [1:0]       dmistat,
   input logic [1:0]       dr_op
);

   logic       armed    = 1'b0;
   logic [2:0] ones_cnt = 3'd0;

   always_ff @(posedge tck) begin
      armed <= 1'b1;
      if (!tms)
         ones_cnt <= 3'd0;
      else if (ones_cnt != 3'd5)
         ones_cnt <= ones_cnt + 3'd1;
   end

   p_reset_hold_r2: assert property (@(posedge tck) disable iff (!armed)
      (state == ST_RESET && tms) |=> (state == ST_RESET));

   p_five_ones_r2: assert property (@(posedge tck) disable iff (!armed)
      (ones_cnt == 3'd5) |-> (state == ST_RESET));

   p_idle_hold_r1: assert property (@(posedge tck) disable iff (!armed)
      (state == ST_IDLE && !tms) |=> (state == ST_IDLE));

   p_exit2_back_r1: assert property (@(posedge tck) disable iff (!armed)
      (state == ST_EX2DR && !tms) |=> (state == ST_SHDR));

   p_reset_ir_r3: assert property (@(posedge tck) disable iff (!armed)
      (state == ST_RESET) |=> (ir_q == INS_IDCODE));

   p_oe_shift_r7: assert property (@(posedge tck) disable iff (!armed)
      tdo_oe == (state == ST_SHDR || state == ST_SHIR));

   p_req_hold_r9: assert property (@(posedge tck) disable iff (!armed)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_data)));

   p_busy_sets_r11: assert property (@(posedge tck) disable iff (!armed)
      (upd_dmi && pending && (dr_op == OP_READ || dr_op == OP_WRITE)) |=> (dmistat == STAT_BUSY));

   p_no_relaunch_r11: assert property (@(posedge tck) disable iff (!armed)
      (upd_dmi && pending) |=> $stable(req_addr));

endmodule

bind dbg_jtag_tap dbg_jtag_tap_chk #(.ABITS(ABITS)) u_chk (
   .tck       (tck),
   .tms       (tms),
   .state     (state),
   .ir_q      (ir_q),
   .tdo_oe    (tdo_oe),
   .req_valid (dmi_req_valid),
   .req_ready (dmi_req_ready),
   .req_addr  (dmi_req_addr),
   .req_data  (dmi_req_data),
   .upd_dmi   (upd_dmi),
   .pending   (pending),
   .dmistat   (dmistat),
   .dr_op     (dr_q[1:0])
);

// File: tb/dbg_jtag_tap_test.sv
`timescale 1ns/1ps
module dbg_jtag_tap_test;

   localparam int          AB     = 7;
   localparam logic [31:0] ID     = 32'h1000_2FFF;
   localparam logic [31:0] CS0    = 32'h0000_0071;   // version 1, abits 7
   localparam logic [63:0] PAT    = 64'hA5C3_9E17_6B2D_F048;

   logic          tck = 1'b0;
   logic          tms = 1'b1;
   logic          tdi = 1'b0;
   logic          tdo, tdo_oe;
   logic          dmi_req_valid;
   logic          dmi_req_ready = 1'b0;
   logic [AB-1:0] dmi_req_addr;
   logic [31:0]   dmi_req_data;
   logic [1:0]    dmi_req_op;
   logic          dmi_rsp_valid = 1'b0;
   logic [31:0]   dmi_rsp_data  = '0;
   logic [1:0]    dmi_rsp_status = 2'd0;

   int n_cmp = 0;
   int n_bad = 0;
   logic last_oe;

   always #2 tck = ~tck;

   dbg_jtag_tap #(.ABITS(AB)) uut (
      .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
      .dmi_req_valid(dmi_req_valid), .dmi_req_ready(dmi_req_ready),
      .dmi_req_addr(dmi_req_addr), .dmi_req_data(dmi_req_data),
      .dmi_req_op(dmi_req_op), .dmi_rsp_valid(dmi_rsp_valid),
      .dmi_rsp_data(dmi_rsp_data), .dmi_rsp_status(dmi_rsp_status)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One test-clock cycle: drive after the falling edge, sample data out there.
   task automatic step(input logic m, input logic d, output logic o);
      @(negedge tck);
      #1;
      o       = tdo;
      last_oe = tdo_oe;
      tms     = m;
      tdi     = d;
      @(posedge tck);
      #1;
   endtask

   task automatic scan_ir(input logic [4:0] v, output logic [4:0] cap);
      logic b;
      step(1'b1, 1'b0, b);
      step(1'b1, 1'b0, b);
      step(1'b0, 1'b0, b);
      step(1'b0, 1'b0, b);
      for (int i = 0; i < 5; i++) begin
         step(i == 4, v[i], b);
         cap[i] = b;
      end
      step(1'b1, 1'b0, b);
      step(1'b0, 1'b0, b);
   endtask

   task automatic scan_dr(input logic [63:0] din, input int n, output logic [63:0] dout);
      logic b;
      dout = '0;
      step(1'b1, 1'b0, b);
      step(1'b0, 1'b0, b);
      step(1'b0, 1'b0, b);
      for (int i = 0; i < n; i++) begin
         step(i == n - 1, din[i], b);
         dout[i] = b;
      end
      step(1'b1, 1'b0, b);
      step(1'b0, 1'b0, b);
   endtask

   task automatic idle(input int n);
      logic b;
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, b);
   endtask

   function automatic logic [63:0] dmi_word(input logic [6:0] a, input logic [31:0] d, input logic [1:0] op);
      return {23'd0, a, d, op};
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge tck);
      n_bad++;
      $display("FAIL R1 watchdog actual=expired expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      logic [4:0]  ic;
      logic [63:0] q, e;
      logic        b;
      int          n;

      #1;
      chk("R2 power-up oe", {63'd0, tdo_oe}, 64'd0);
      chk("R9 power-up req_valid", {63'd0, dmi_req_valid}, 64'd0);

      // Power-up state is reset: first TMS=0 edge reaches Idle with IDCODE selected.
      step(1'b0, 1'b0, b);
      scan_dr(PAT, 40, q);
      e = {24'd0, PAT[7:0], ID};
      chk("R5 idcode after power-up", q[39:0], e[39:0]);

      // Sweep every instruction code.
      for (int c = 0; c < 32; c++) begin
         scan_ir(5'(c), ic);
         chk("R4 capture-ir pattern", {59'd0, ic}, 64'd1);
         if (c == 5'h01) begin
            scan_dr(PAT, 40, q);
            e = {24'd0, PAT[7:0], ID};
            chk("R5 idcode scan", q, e);
         end else if (c == 5'h10) begin
            scan_dr(64'd0, 32, q);
            chk("R8 dtmcs idle", q, {32'd0, CS0});
         end else if (c == 5'h11) begin
            scan_dr(64'd0, 41, q);
            chk("R10 dmi idle capture", q, 64'd0);
         end else begin
            scan_dr(PAT, 12, q);
            e = {52'd0, PAT[10:0], 1'b0};
            chk("R6 bypass scan", q, e);
         end
      end

      // Reset from many states by five TMS-high edges.
      for (int k = 0; k <= 16; k++) begin
         logic [15:0] walk = 16'b1010_0111_1010_1001; // bit0 first
         scan_ir(5'h1F, ic);
         for (int j = 0; j < k; j++) step(walk[j], 1'b0, b);
         for (int j = 0; j < 5; j++) step(1'b1, 1'b0, b);
         step(1'b0, 1'b0, b);
         scan_dr(PAT, 32, q);
         chk("R2 R3 five ones then idcode", q, {32'd0, ID});
      end

      // Pause / Exit2 return to Shift inside a data scan.
      step(1'b1, 1'b0, b);
      step(1'b0, 1'b0, b);
      step(1'b0, 1'b0, b);
      q = '0;
      for (int i = 0; i < 10; i++) begin step(i == 9, 1'b0, b); q[i] = b; end
      chk("R7 oe during shift", {63'd0, last_oe}, 64'd1);
      step(1'b0, 1'b0, b);
      step(1'b0, 1'b0, b);
      chk("R7 oe low in pause", {63'd0, last_oe}, 64'd0);
      chk("R7 tdo low in pause", {63'd0, b}, 64'd0);
      step(1'b1, 1'b0, b);
      step(1'b0, 1'b0, b);
      for (int i = 10; i < 32; i++) begin step(i == 31, 1'b0, b); q[i] = b; end
      step(1'b1, 1'b0, b);
      step(1'b0, 1'b0, b);
      chk("R1 pause exit2 resume", q, {32'd0, ID});

      // Access word: write, hold until ready, response.
      scan_ir(5'h11, ic);
      scan_dr(dmi_word(7'h15, 32'hCAFE_F00D, 2'd2), 41, q);
      chk("R9 req valid", {63'd0, dmi_req_valid}, 64'd1);
      chk("R9 req addr", {57'd0, dmi_req_addr}, 64'h15);
      chk("R9 req data", {32'd0, dmi_req_data}, 64'hCAFE_F00D);
      chk("R9 req op", {62'd0, dmi_req_op}, 64'd2);
      idle(3);
      chk("R9 req held", {63'd0, dmi_req_valid}, 64'd1);
      dmi_req_ready = 1'b1;
      idle(1);
      dmi_req_ready = 1'b0;
      chk("R9 req dropped after ready", {63'd0, dmi_req_valid}, 64'd0);
      dmi_rsp_valid = 1'b1; dmi_rsp_data = 32'h1234_5678; dmi_rsp_status = 2'd0;
      idle(1);
      dmi_rsp_valid = 1'b0;
      scan_dr(64'd0, 41, q);
      chk("R10 capture after response", q, dmi_word(7'h15, 32'h1234_5678, 2'd0));

      // Busy: read pending, second write collides.
      scan_dr(dmi_word(7'h22, 32'd0, 2'd1), 41, q);
      chk("R9 read req addr", {57'd0, dmi_req_addr}, 64'h22);
      scan_dr(dmi_word(7'h33, 32'h0BAD_0BAD, 2'd2), 41, q);
      chk("R10 pending reads busy", {62'd0, q[1:0]}, 64'd3);
      chk("R11 no second launch", {57'd0, dmi_req_addr}, 64'h22);
      chk("R11 first op kept", {62'd0, dmi_req_op}, 64'd1);
      scan_ir(5'h10, ic);
      scan_dr(64'd0, 32, q);
      chk("R11 sticky busy in dtmcs", q, {32'd0, CS0 | 32'hC00});
      dmi_req_ready = 1'b1;
      idle(1);
      dmi_req_ready = 1'b0;
      dmi_rsp_valid = 1'b1; dmi_rsp_data = 32'h0000_00AA; dmi_rsp_status = 2'd2;
      idle(1);
      dmi_rsp_valid = 1'b0;
      scan_dr(64'd0, 32, q);
      chk("R12 busy not overwritten", q, {32'd0, CS0 | 32'hC00});
      scan_dr(64'h1_0000, 32, q);
      scan_dr(64'd0, 32, q);
      chk("R8 status cleared", q, {32'd0, CS0});

      // Failed response recorded when status is clear.
      scan_ir(5'h11, ic);
      scan_dr(dmi_word(7'h40, 32'd0, 2'd1), 41, q);
      dmi_req_ready = 1'b1;
      idle(1);
      dmi_req_ready = 1'b0;
      dmi_rsp_valid = 1'b1; dmi_rsp_data = 32'hFEED_0001; dmi_rsp_status = 2'd2;
      idle(1);
      dmi_rsp_valid = 1'b0;
      scan_dr(64'd0, 41, q);
      chk("R12 failed status captured", q, dmi_word(7'h40, 32'hFEED_0001, 2'd2));
      scan_ir(5'h10, ic);
      scan_dr(64'd0, 32, q);
      chk("R12 failed status in dtmcs", q, {32'd0, CS0 | 32'h800});

      // An op of 0 issues nothing.
      scan_ir(5'h11, ic);
      n = 0;
      scan_dr(dmi_word(7'h7F, 32'h5555_AAAA, 2'd0), 41, q);
      chk("R9 nop issues nothing", {63'd0, dmi_req_valid}, 64'd0);
      chk("R9 nop keeps addr", {57'd0, dmi_req_addr}, 64'h40);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule